// File: doc/BRIEF.md
# Paged Address Translation Unit

The block maps a 24-bit logical CPU address onto a physical RAM address. It does this through a map RAM of 1024 entries, one 16-bit word per entry, with one entry for each 4 KB page. The low 4 MB of logical space is translated. Anything above that range goes through unchanged. On every translated access the block also advances the two-bit use status kept in the page's entry: absent, fresh, read or dirty. The updated word is written back in the same pipeline step that produces the translation.

Software fills the map through a dedicated load port. Each access result carries the physical address, a flag that selects expansion RAM rather than base RAM, and a flag that marks a read beyond the fitted expansion RAM (the RAM side answers such a read with all ones). The result also carries the page entry after its status update, so that a downstream permission check can use it. Each access gives one result two clock edges after it is presented, and an access can be presented every cycle.

Top module: `page_translator`

## Requirements
- R1: An access whose logical address is 0x400000 or higher is not translated. Its physical address equals the logical address, the expansion flag and the out-of-range flag are 0, the entry output is 0, and no map entry changes.
- R2: For a translated access, the page index is logical bits 21:12. The physical address is 00, then entry bits 9:0, then logical bits 11:0.
- R3: Entry bits 14:13 hold the status: 0 absent, 1 fresh, 2 read, 3 dirty. A fresh page becomes 2 on a read and 3 on a write.
- R4: A page in status 2 or 3 becomes 3 on a write. A read leaves its status unchanged.
- R5: A page in status 0 keeps its entry unchanged, and its access is still translated.
- R6: A status update keeps entry bits 15 and 12:0 unchanged.
- R7: The expansion flag is 1 exactly when a translated physical address is 0x200000 or higher.
- R8: The out-of-range flag is 1 only for a read with the expansion flag set whose physical address minus 0x200000 is at least the expansion size (default 0x100000). A write never sets it.
- R9: The result of an access, with out_vld high, appears two rising edges after the access is sampled. Back-to-back accesses to one page each see the status left by the one before.
- R10: A load writes its word into the indexed entry. An access sampled on the same edge as a load to the same entry uses the loaded word.
- R11: When a load and a status write-back fall on the same edge, the load is written and the write-back is discarded.
- R12: While reset is high and directly after it, out_vld and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write access, 0 = read |
| acc_addr | input | 24 | Logical address |
| ld_en | input | 1 | Map entry load strobe |
| ld_idx | input | 10 | Entry index to load |
| ld_data | input | 16 | Entry word to load |
| out_vld | output | 1 | Result valid |
| out_paddr | output | 24 | Physical (or passed-through) address |
| out_exp | output | 1 | Expansion RAM selected |
| out_oor | output | 1 | Read beyond fitted expansion RAM |
| out_ent | output | 16 | Page entry after status update (0 when not translated) |

## Verification
The hardest case to reach is a write-back landing on the same edge on which the map RAM is read for a following access to the same page. If the bypass path fails there, the second access silently works from a stale status. The stimulus reaches this case by issuing a read, a write and a read to one fresh page on three consecutive cycles, so that each later access depends on the update made by the access just before it. Two more collisions are set up with exact timing. In one, a load and an access share an edge. In the other, a load lands on the edge of a pending write-back, and a read afterwards shows which word was kept.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

  typedef enum logic [1:0] {
    PG_ABSENT = 2'd0,
    PG_FRESH  = 2'd1,
    PG_READ   = 2'd2,
    PG_DIRTY  = 2'd3
  } pg_state_e;

  // Status field low bit inside a map entry
  localparam int ST_LO = 13;

  // Next use status for one access
  function automatic logic [1:0] pg_next(input logic [1:0] cur, input logic is_wr);
    logic [1:0] nxt;
    nxt = cur;
    if (cur == PG_FRESH)
      nxt = is_wr ? PG_DIRTY : PG_READ;
    else if (cur != PG_ABSENT && is_wr)
      nxt = PG_DIRTY;
    return nxt;
  endfunction

endpackage

// File: rtl/pgx_map_ram.sv
module pgx_map_ram #(
  parameter int IDX_W = 10,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  // Simple dual port, read-first: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pgx_status_upd.sv
module pgx_status_upd
  import pgx_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          active,
  input  logic          is_wr,
  input  logic [DW-1:0] ent_in,
  output logic [DW-1:0] ent_out,
  output logic          wb_en
);
  logic [1:0] cur_st, nxt_st;

  always_comb begin
    cur_st  = ent_in[ST_LO +: 2];
    nxt_st  = pg_next(cur_st, is_wr);
    ent_out = ent_in;
    ent_out[ST_LO +: 2] = nxt_st;
    wb_en   = active && (nxt_st != cur_st);
  end
endmodule

// File: rtl/pgx_phys_decode.sv
module pgx_phys_decode #(
  parameter int LA_W  = 24,
  parameter int PPN_W = 10,
  parameter int OFF_W = 12,
  parameter int unsigned BASE_LIMIT = 32'h20_0000,
  parameter int unsigned EXP_BYTES  = 32'h10_0000
) (
  input  logic             xlate,
  input  logic             is_wr,
  input  logic [LA_W-1:0]  la,
  input  logic [PPN_W-1:0] ppn,
  output logic [LA_W-1:0]  pa,
  output logic             exp_sel,
  output logic             oor
);
  localparam int PAD_W = LA_W - PPN_W - OFF_W;
  localparam logic [LA_W-1:0] BASE_L = LA_W'(BASE_LIMIT);
  localparam logic [LA_W-1:0] EXP_L  = LA_W'(EXP_BYTES);

  logic [LA_W-1:0] pa_x, exp_off;

  always_comb begin
    pa_x    = {{PAD_W{1'b0}}, ppn, la[OFF_W-1:0]};
    exp_off = pa_x - BASE_L;
    exp_sel = xlate && (pa_x >= BASE_L);
    oor     = exp_sel && !is_wr && (exp_off >= EXP_L);
    pa      = xlate ? pa_x : la;
  end
endmodule

// File: rtl/page_translator.sv
module page_translator
  import pgx_pkg::*;
#(
  parameter int LA_W  = 24,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10,
  parameter int ENT_W = 16,
  parameter int PPN_W = 10,
  parameter int unsigned XLATE_LIMIT = 32'h40_0000,
  parameter int unsigned BASE_LIMIT  = 32'h20_0000,
  parameter int unsigned EXP_BYTES   = 32'h10_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_vld,
  input  logic             acc_wr,
  input  logic [LA_W-1:0]  acc_addr,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [ENT_W-1:0] ld_data,
  output logic             out_vld,
  output logic [LA_W-1:0]  out_paddr,
  output logic             out_exp,
  output logic             out_oor,
  output logic [ENT_W-1:0] out_ent
);
  localparam int IDX_HI = OFF_W + IDX_W - 1;
  localparam logic [LA_W-1:0] XL_LIM = LA_W'(XLATE_LIMIT);

  // Stage 0: RAM read request
  logic [IDX_W-1:0] acc_idx;
  assign acc_idx = acc_addr[IDX_HI:OFF_W];

  // Shared write port: a load overrides a status write-back
  logic             wb_en, ram_we;
  logic [IDX_W-1:0] ram_waddr;
  logic [ENT_W-1:0] ram_wdata, ram_rdata, new_ent;

  // Stage 1 state
  logic             s1_vld, s1_wr, s1_xl;
  logic [LA_W-1:0]  s1_addr;
  logic             fwd_hit;
  logic [ENT_W-1:0] fwd_ent, cur_ent;

  assign ram_we    = ld_en || wb_en;
  assign ram_waddr = ld_en ? ld_idx  : s1_addr[IDX_HI:OFF_W];
  assign ram_wdata = ld_en ? ld_data : new_ent;

  pgx_map_ram #(.IDX_W(IDX_W), .DW(ENT_W)) map_i (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (acc_vld),
    .raddr (acc_idx),
    .rdata (ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_wr   <= 1'b0;
      s1_xl   <= 1'b0;
      s1_addr <= '0;
      fwd_hit <= 1'b0;
      fwd_ent <= '0;
    end else begin
      s1_vld  <= acc_vld;
      s1_wr   <= acc_wr;
      s1_xl   <= acc_vld && (acc_addr < XL_LIM);
      s1_addr <= acc_addr;
      // Bypass a write landing on the same edge as the read
      fwd_hit <= acc_vld && ram_we && (ram_waddr == acc_idx);
      fwd_ent <= ram_wdata;
    end
  end

  assign cur_ent = fwd_hit ? fwd_ent : ram_rdata;

  pgx_status_upd #(.DW(ENT_W)) upd_i (
    .active  (s1_vld && s1_xl),
    .is_wr   (s1_wr),
    .ent_in  (cur_ent),
    .ent_out (new_ent),
    .wb_en   (wb_en)
  );

  logic [LA_W-1:0] pa_c;
  logic            exp_c, oor_c;

  pgx_phys_decode #(
    .LA_W(LA_W), .PPN_W(PPN_W), .OFF_W(OFF_W),
    .BASE_LIMIT(BASE_LIMIT), .EXP_BYTES(EXP_BYTES)
  ) dec_i (
    .xlate   (s1_xl),
    .is_wr   (s1_wr),
    .la      (s1_addr),
    .ppn     (cur_ent[PPN_W-1:0]),
    .pa      (pa_c),
    .exp_sel (exp_c),
    .oor     (oor_c)
  );

  // Stage 2: registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      out_paddr <= '0;
      out_exp   <= 1'b0;
      out_oor   <= 1'b0;
      out_ent   <= '0;
    end else begin
      out_vld   <= s1_vld;
      out_paddr <= s1_vld ? pa_c : '0;
      out_exp   <= s1_vld && exp_c;
      out_oor   <= s1_vld && oor_c;
      out_ent   <= (s1_vld && s1_xl) ? new_ent : '0;
    end
  end

  // R9
  lat_chk: assert property (@(posedge clk) disable iff (rst)
    acc_vld |=> ##1 out_vld);

  // R1
  pass_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && $past(acc_addr, 2) >= XL_LIM) |->
      (out_paddr == $past(acc_addr, 2) && !out_exp && !out_oor));

  // R8
  oor_chk: assert property (@(posedge clk) disable iff (rst)
    out_oor |-> (out_exp && !$past(acc_wr, 2)));

  // R4
  st_rise_chk: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (new_ent[ST_LO +: 2] > cur_ent[ST_LO +: 2]));

  // R5
  absent_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && cur_ent[ST_LO +: 2] == PG_ABSENT) |-> !wb_en);

  // R6
  keep_chk: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> ((new_ent ^ cur_ent) & ~(ENT_W'(3) << ST_LO)) == '0);

endmodule

// File: tb/page_translator_tb.sv
`timescale 1ns/1ps
module page_translator_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        acc_vld, acc_wr;
  logic [23:0] acc_addr;
  logic        ld_en;
  logic [9:0]  ld_idx;
  logic [15:0] ld_data;
  logic        out_vld, out_exp, out_oor;
  logic [23:0] out_paddr;
  logic [15:0] out_ent;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  page_translator dut_i (
    .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .out_vld(out_vld), .out_paddr(out_paddr), .out_exp(out_exp),
    .out_oor(out_oor), .out_ent(out_ent)
  );

  // {wr, logical, expected physical, exp, oor, expected entry}
  localparam int NV = 18;
  localparam logic [66:0] TBL [NV] = '{
    {1'b0, 24'h001ABC, 24'h005ABC, 1'b0, 1'b0, 16'h4005}, // R2 R3 fresh->read
    {1'b0, 24'h001000, 24'h005000, 1'b0, 1'b0, 16'h4005}, // R4 read keeps
    {1'b1, 24'h001FFE, 24'h005FFE, 1'b0, 1'b0, 16'h6005}, // R4 write->dirty
    {1'b0, 24'h001002, 24'h005002, 1'b0, 1'b0, 16'h6005}, // R4 dirty stays
    {1'b1, 24'h002123, 24'h203123, 1'b1, 1'b0, 16'hFE03}, // R3 R6 R7
    {1'b0, 24'h003456, 24'h3FF456, 1'b1, 1'b1, 16'h03FF}, // R5 R8
    {1'b1, 24'h003456, 24'h3FF456, 1'b1, 1'b0, 16'h03FF}, // R5 R8 write never oor
    {1'b0, 24'h3FF7FF, 24'h0107FF, 1'b0, 1'b0, 16'h4010}, // R4
    {1'b1, 24'h3FF000, 24'h010000, 1'b0, 1'b0, 16'h6010}, // R4
    {1'b0, 24'h400000, 24'h400000, 1'b0, 1'b0, 16'h0000}, // R1 lowest pass-through
    {1'b1, 24'hC12345, 24'hC12345, 1'b0, 1'b0, 16'h0000}, // R1
    {1'b0, 24'h7FFFFF, 24'h7FFFFF, 1'b0, 1'b0, 16'h0000}, // R1
    {1'b1, 24'h404000, 24'h404000, 1'b0, 1'b0, 16'h0000}, // R1 would hit page 4
    {1'b0, 24'h004010, 24'h100010, 1'b0, 1'b0, 16'h4100}, // R1 page 4 untouched, R3
    {1'b0, 24'h3FFFFF, 24'h010FFF, 1'b0, 1'b0, 16'h6010}, // R2 top translated
    {1'b0, 24'h006FFF, 24'h2FFFFF, 1'b1, 1'b0, 16'h42FF}, // R7 R8 last in range
    {1'b0, 24'h005000, 24'h300000, 1'b1, 1'b1, 16'h4300}, // R8 first out of range
    {1'b0, 24'h007FFF, 24'h1FFFFF, 1'b0, 1'b0, 16'h41FF}  // R7 last base byte
  };

  task automatic check(input string tag, input logic [23:0] pa, input logic e,
                       input logic o, input logic [15:0] ent);
    n_chk++;
    if (out_vld !== 1'b1 || out_paddr !== pa || out_exp !== e || out_oor !== o || out_ent !== ent) begin
      n_bad++;
      $display("FAIL %s: got vld=%b pa=%h exp=%b oor=%b ent=%h, want vld=1 pa=%h exp=%b oor=%b ent=%h",
               tag, out_vld, out_paddr, out_exp, out_oor, out_ent, pa, e, o, ent);
    end
  endtask

  // Called at a negedge; returns at a negedge
  task automatic load(input logic [9:0] idx, input logic [15:0] d);
    ld_en = 1'b1; ld_idx = idx; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic access(input logic wr, input logic [23:0] a);
    acc_vld = 1'b1; acc_wr = wr; acc_addr = a;
    @(negedge clk);
    acc_vld = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang, want completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; acc_vld = 1'b0; acc_wr = 1'b0; acc_addr = '0;
    ld_en = 1'b0; ld_idx = '0; ld_data = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    n_chk++;
    if (out_vld !== 1'b0 || out_paddr !== '0 || out_exp !== 1'b0 || out_oor !== 1'b0 || out_ent !== '0) begin
      n_bad++;
      $display("FAIL R12: got vld=%b pa=%h ent=%h, want all zero", out_vld, out_paddr, out_ent);
    end
    rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (out_vld !== 1'b0) begin
      n_bad++;
      $display("FAIL R12: got vld=%b after reset, want 0", out_vld);
    end

    // R10 loads
    load(10'h001, 16'h2005);
    load(10'h002, 16'hBE03);
    load(10'h003, 16'h03FF);
    load(10'h004, 16'h2100);
    load(10'h005, 16'h4300);
    load(10'h006, 16'h42FF);
    load(10'h007, 16'h41FF);
    load(10'h008, 16'h2020);
    load(10'h009, 16'h0009);
    load(10'h00A, 16'h200A);
    load(10'h3FF, 16'h4010);

    for (int i = 0; i < NV; i++) begin
      access(TBL[i][66], TBL[i][65:42]);
      check($sformatf("table vector %0d", i), TBL[i][41:18], TBL[i][17], TBL[i][16], TBL[i][15:0]);
    end

    // R9 back-to-back on one fresh page
    acc_vld = 1'b1; acc_wr = 1'b0; acc_addr = 24'h008000;
    @(negedge clk);
    acc_wr = 1'b1; acc_addr = 24'h008004;
    @(negedge clk);
    check("R9 first of burst", 24'h020000, 1'b0, 1'b0, 16'h4020);
    acc_wr = 1'b0; acc_addr = 24'h008008;
    @(negedge clk);
    check("R9 second of burst", 24'h020004, 1'b0, 1'b0, 16'h6020);
    acc_vld = 1'b0;
    @(negedge clk);
    check("R9 third of burst", 24'h020008, 1'b0, 1'b0, 16'h6020);

    // R10 load and access to the same entry on one edge
    acc_vld = 1'b1; acc_wr = 1'b0; acc_addr = 24'h009040;
    ld_en = 1'b1; ld_idx = 10'h009; ld_data = 16'h2111;
    @(negedge clk);
    acc_vld = 1'b0; ld_en = 1'b0;
    @(negedge clk);
    check("R10 same-edge load", 24'h111040, 1'b0, 1'b0, 16'h4111);

    // R11 load collides with a pending write-back
    acc_vld = 1'b1; acc_wr = 1'b0; acc_addr = 24'h00A000;
    @(negedge clk);
    acc_vld = 1'b0;
    ld_en = 1'b1; ld_idx = 10'h00A; ld_data = 16'h2077;
    @(negedge clk);
    ld_en = 1'b0;
    check("R11 access before collision", 24'h00A000, 1'b0, 1'b0, 16'h400A);
    access(1'b0, 24'h00A000);
    check("R11 load kept over write-back", 24'h077000, 1'b0, 1'b0, 16'h4077);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule